// File: doc/BRIEF.md
# Dual-Lane ADC Serial Frame Transmitter

This block is the digital side of a two-channel sampling converter's serial port. Each channel's 16-bit conversion word reaches the block through a parallel load port. A host reads the words over a serial link, driving an active-low chip select and a serial clock. Both inputs are brought into the block's own clock domain by a synchronizer chain. Edges are then detected there, so every serial event acts on the system clock.

When chip select goes low, both data lanes leave high impedance and drive 0. The first fifteen falling serial clock edges stand in for the conversion time, and both lanes stay at 0 during them. From the 16th falling edge on, each lane presents its channel's word, most significant bit first. In the single-lane arrangement, lane A carries channel A and then channel B, and lane B stays in high impedance.

When chip select rises, the frame ends. The block reports through a one-cycle done pulse and a status bit that tells whether the frame received enough clock edges.

Top module: `adcfx_frame_tx`

## Requirements
- R1: After reset, both output enables, both data outputs, the done pulse and the status bit are all 0.
- R2: A chip select falling edge sets oe_a to 1, sets oe_b to 1 only in dual-lane mode, and drives 0 on both data outputs.
- R3: During falling serial clock edges 1 to 15 of a frame, both data outputs read 0.
- R4: In dual-lane mode, falling edge n (16 to 31) presents bit 31-n of channel A on sdo_a and bit 31-n of channel B on sdo_b, MSB first.
- R5: Once the last data bit has been launched, both outputs drive 0 until the frame ends. The falling-edge count saturates at 63, so extra edges never launch data again.
- R6: A chip select rising edge clears both output enables and both data outputs, and raises frame_done for exactly one clock cycle.
- R7: frame_ok, updated with each frame_done pulse, is 1 only if the frame saw at least 32 falling edges (dual-lane) or at least 48 (single-lane). Otherwise it is 0.
- R8: In single-lane mode, sdo_a carries channel A on edges 16 to 31 and channel B on edges 32 to 47, each MSB first. oe_b and sdo_b stay 0 for the whole frame.
- R9: ld_valid captures ld_word_a and ld_word_b only while chip select is high and no frame is active. A load pulse during a frame changes neither that frame nor the next one.
- R10: Serial clock edges while chip select is high drive nothing and are not counted toward the next frame.
- R11: lane_mode is latched at the chip select falling edge. Bit 0 set selects single-lane, and bit 1 has no effect, so 00 and 10 both select dual-lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, idle high |
| sclk | input | 1 | Host serial clock |
| lane_mode | input | 2 | Lane arrangement; bit 0 set selects single-lane |
| ld_valid | input | 1 | Load strobe for the conversion words |
| ld_word_a | input | 16 | Channel A conversion word |
| ld_word_b | input | 16 | Channel B conversion word |
| sdo_a | output | 1 | Lane A serial data |
| oe_a | output | 1 | Lane A drive enable (0 means high impedance) |
| sdo_b | output | 1 | Lane B serial data |
| oe_b | output | 1 | Lane B drive enable (0 means high impedance) |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| frame_ok | output | 1 | Frame validity from the falling-edge count |

## Verification
A change on cs_n or sclk passes through two synchronizer stages and an edge register. The block's response therefore appears three system clocks after the host edge. That response may be a new data bit, a change in the enables, or the done pulse with its status. The bench applies every host edge at a falling system clock edge and waits three falling edges before it samples. It samples frame_done there and once more one clock later, to confirm the pulse lasts a single cycle. Load pulses are a single cycle, sampled directly, and are driven only at points where the chip select state is settled.

// File: rtl/adcfx_pkg.sv
package adcfx_pkg;
   typedef enum logic {
      LANE_DUAL   = 1'b0,
      LANE_SINGLE = 1'b1
   } lane_arr_e;
endpackage

// File: rtl/adcfx_sync.sv
// Multi-stage synchronizer with edge detection behind the last stage.
module adcfx_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] fall,
   output logic [WIDTH-1:0] rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("adcfx_sync: STAGES must be at least 2");
   end

   logic [STAGES:0][WIDTH-1:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= {(STAGES+1){RST_VAL}};
      else        stg <= {stg[STAGES-1:0], din};
   end

   assign level = stg[STAGES-1];
   assign fall  = stg[STAGES] & ~stg[STAGES-1];
   assign rise  = ~stg[STAGES] & stg[STAGES-1];
endmodule

// File: rtl/adcfx_edge_ctr.sv
// Frame activity flag and saturating falling-edge counter.
module adcfx_edge_ctr #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             tick,
   output logic             active,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   assign cnt_nxt = (cnt == CMAX) ? CMAX : cnt + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (stop) begin
         active <= 1'b0;
      end else if (tick && active) begin
         cnt <= cnt_nxt;
      end
   end

   // R5
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt == CMAX && !start) |=> (cnt == CMAX));
endmodule

// File: rtl/adcfx_lane.sv
// One serial data lane: shift register, launch window and drive enable.
module adcfx_lane #(
   parameter int unsigned W     = 16,
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             tick,
   input  logic             en_at_start,
   input  logic [W-1:0]     word,
   input  logic [CNT_W-1:0] n,
   input  logic [CNT_W-1:0] lo,
   input  logic [CNT_W-1:0] hi,
   output logic             sdo,
   output logic             oe
);
   if (W < 2) begin : g_bad_w
      $error("adcfx_lane: W must be at least 2");
   end

   logic [W-1:0] sh;
   logic         in_win;

   assign in_win = (n >= lo) && (n <= hi);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh  <= '0;
         sdo <= 1'b0;
         oe  <= 1'b0;
      end else if (start) begin
         sh  <= word;
         sdo <= 1'b0;
         oe  <= en_at_start;
      end else if (stop) begin
         sdo <= 1'b0;
         oe  <= 1'b0;
      end else if (tick) begin
         if (oe && in_win) begin
            sdo <= sh[W-1];
            sh  <= {sh[W-2:0], 1'b0};
         end else begin
            sdo <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adcfx_frame_tx.sv
module adcfx_frame_tx
   import adcfx_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CNT_W       = 6,
   parameter int unsigned LEAD_EDGES  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SINGLE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic [1:0]        lane_mode,
   input  logic              ld_valid,
   input  logic [DATA_W-1:0] ld_word_a,
   input  logic [DATA_W-1:0] ld_word_b,
   output logic              sdo_a,
   output logic              oe_a,
   output logic              sdo_b,
   output logic              oe_b,
   output logic              frame_done,
   output logic              frame_ok
);
   localparam int unsigned DUAL_EDGES   = LEAD_EDGES + DATA_W;
   localparam int unsigned SINGLE_EDGES = LEAD_EDGES + 2*DATA_W;
   localparam int unsigned CNT_MAX      = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] LO_N     = CNT_W'(LEAD_EDGES);
   localparam logic [CNT_W-1:0] HI_DUAL  = CNT_W'(DUAL_EDGES - 1);
   localparam logic [CNT_W-1:0] HI_SING  = CNT_W'(SINGLE_EDGES - 1);
   localparam logic [CNT_W-1:0] NEED_DUAL = CNT_W'(DUAL_EDGES);
   localparam logic [CNT_W-1:0] NEED_SING = CNT_W'(SINGLE_EDGES);

   if (SINGLE_EDGES > CNT_MAX) begin : g_bad_cnt
      $error("adcfx_frame_tx: CNT_W too narrow for the frame length");
   end
   if (LEAD_EDGES < 1) begin : g_bad_lead
      $error("adcfx_frame_tx: LEAD_EDGES must be at least 1");
   end

   logic [1:0]       s_lvl, s_fall, s_rise;
   logic             cs_lvl, cs_fall, cs_rise, sclk_fall;
   logic             start, stop, tick, active;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic [DATA_W-1:0] hold_a, hold_b;
   lane_arr_e        mode_q;
   lane_arr_e        mode_in;
   logic [CNT_W-1:0] hi_a;

   adcfx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({cs_n, sclk}),
      .level(s_lvl), .fall(s_fall), .rise(s_rise)
   );

   assign cs_lvl    = s_lvl[1];
   assign cs_fall   = s_fall[1];
   assign cs_rise   = s_rise[1];
   assign sclk_fall = s_fall[0];

   assign start = cs_fall && !active;
   assign stop  = cs_rise && active;
   assign tick  = sclk_fall && active && !stop;

   adcfx_edge_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick),
      .active(active), .cnt(cnt), .cnt_nxt(cnt_nxt)
   );

   // Lane arrangement variant chosen by parameter
   if (SINGLE_EN) begin : g_mode_sel
      assign mode_in = lane_mode[0] ? LANE_SINGLE : LANE_DUAL;
   end else begin : g_mode_fixed
      assign mode_in = LANE_DUAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_a <= '0;
         hold_b <= '0;
         mode_q <= LANE_DUAL;
      end else begin
         if (ld_valid && cs_lvl && !active) begin
            hold_a <= ld_word_a;
            hold_b <= ld_word_b;
         end
         if (start) mode_q <= mode_in;
      end
   end

   assign hi_a = (mode_q == LANE_SINGLE) ? HI_SING : HI_DUAL;

   adcfx_lane #(.W(2*DATA_W), .CNT_W(CNT_W)) u_lane_a (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick),
      .en_at_start(1'b1), .word({hold_a, hold_b}),
      .n(cnt_nxt), .lo(LO_N), .hi(hi_a), .sdo(sdo_a), .oe(oe_a)
   );

   adcfx_lane #(.W(DATA_W), .CNT_W(CNT_W)) u_lane_b (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick),
      .en_at_start(mode_in == LANE_DUAL), .word(hold_b),
      .n(cnt_nxt), .lo(LO_N), .hi(HI_DUAL), .sdo(sdo_b), .oe(oe_b)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_done <= 1'b0;
         frame_ok   <= 1'b0;
      end else if (stop) begin
         frame_done <= 1'b1;
         frame_ok   <= (mode_q == LANE_SINGLE) ? (cnt >= NEED_SING)
                                               : (cnt >= NEED_DUAL);
      end else begin
         frame_done <= 1'b0;
      end
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R6
   idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_a || oe_b) |-> active);

   // R8
   single_b_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode_q == LANE_SINGLE) |-> (!oe_b && !sdo_b));

   // R3
   lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt < LO_N) |-> (!sdo_a && !sdo_b));
endmodule

// File: tb/adcfx_frame_tx_bench.sv
module adcfx_frame_tx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic [1:0]  lane_mode = 2'b00;
   logic        ld_valid = 1'b0;
   logic [15:0] ld_word_a = '0;
   logic [15:0] ld_word_b = '0;
   logic        sdo_a, oe_a, sdo_b, oe_b, frame_done, frame_ok;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [15:0] m_a = '0;
   logic [15:0] m_b = '0;

   always #5 clk = ~clk;

   adcfx_frame_tx u_adcfx_frame_tx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
      .lane_mode(lane_mode), .ld_valid(ld_valid),
      .ld_word_a(ld_word_a), .ld_word_b(ld_word_b),
      .sdo_a(sdo_a), .oe_a(oe_a), .sdo_b(sdo_b), .oe_b(oe_b),
      .frame_done(frame_done), .frame_ok(frame_ok)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   function automatic logic exp_bit(input bit single, input logic [15:0] a,
                                    input logic [15:0] b, input int n, input bit lane_b);
      if (lane_b) begin
         if (single) return 1'b0;
         if (n >= 16 && n <= 31) return b[31-n];
         return 1'b0;
      end
      if (n >= 16 && n <= 31) return a[31-n];
      if (single && n >= 32 && n <= 47) return b[47-n];
      return 1'b0;
   endfunction

   function automatic string tag_for(input bit single, input int n);
      if (n < 16) return "R3";
      if (!single && n <= 31) return "R4";
      if (single && n <= 47) return "R8";
      return "R5";
   endfunction

   task automatic load_words(input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      ld_valid = 1'b1; ld_word_a = a; ld_word_b = b;
      @(negedge clk);
      ld_valid = 1'b0;
      m_a = a; m_b = b;  // R9: idle load is captured
   endtask

   task automatic run_frame(input logic [15:0] a, input logic [15:0] b,
                            input logic [1:0] md, input int edges,
                            input bit do_load, input bit midload);
      bit single;
      int need;
      single = md[0];  // R11: bit 1 ignored
      if (do_load) load_words(a, b);
      @(negedge clk);
      lane_mode = md;
      cs_n = 1'b0;
      settle();
      check("R2", oe_a, 1);
      check(single ? "R8" : "R2", oe_b, single ? 0 : 1);
      check("R2", {sdo_a, sdo_b}, 0);
      for (int n = 1; n <= edges; n++) begin
         sclk = 1'b0;
         settle();
         check(tag_for(single, n), sdo_a, exp_bit(single, m_a, m_b, n, 1'b0));
         check(single ? "R8" : tag_for(single, n), sdo_b, exp_bit(single, m_a, m_b, n, 1'b1));
         if (single) check("R8", oe_b, 0);
         sclk = 1'b1;
         if (midload && n == 5) begin
            @(negedge clk);
            ld_valid = 1'b1; ld_word_a = ~m_a; ld_word_b = ~m_b;
            @(negedge clk);
            ld_valid = 1'b0;
         end
         settle();
      end
      cs_n = 1'b1;
      settle();
      need = single ? 48 : 32;
      check("R6", frame_done, 1);
      check("R7", frame_ok, ((edges > 63 ? 63 : edges) >= need) ? 1 : 0);
      check("R6", {oe_a, oe_b, sdo_a, sdo_b}, 0);
      @(negedge clk);
      check("R6", frame_done, 0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd5171));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1
      check("R1", {oe_a, oe_b, sdo_a, sdo_b, frame_done, frame_ok}, 0);

      // R10: idle serial clocks drive nothing
      for (int i = 0; i < 12; i++) begin
         sclk = ~sclk;
         settle();
         check("R10", {oe_a, oe_b, sdo_a, sdo_b, frame_done}, 0);
      end
      sclk = 1'b1;
      settle();

      // directed corner cases
      run_frame(16'hA5C3, 16'h3C5A, 2'b00, 32, 1, 0);  // R4 exact minimum, R10 idle edges not counted
      run_frame(16'hFFFF, 16'h0001, 2'b00, 31, 1, 0);  // R7 one short
      run_frame(16'h8001, 16'h7FFE, 2'b01, 48, 1, 0);  // R8 exact
      run_frame(16'h1234, 16'hFEDC, 2'b11, 47, 1, 0);  // R8/R7 one short
      run_frame(16'hC0DE, 16'hBEEF, 2'b00, 70, 1, 0);  // R5 saturation
      run_frame(16'h0F0F, 16'hF0F0, 2'b10, 33, 1, 0);  // R11 bit1 ignored
      run_frame(16'h5555, 16'hAAAA, 2'b00, 35, 1, 1);  // R9 mid-frame load
      run_frame(16'h0000, 16'h0000, 2'b00, 32, 0, 0);  // R9 no reload: old words
      run_frame(16'h0000, 16'h0000, 2'b01, 10, 0, 0);  // R7 short single

      // constrained random frames
      for (int k = 0; k < 24; k++) begin
         logic [15:0] ra, rb;
         logic [1:0]  rm;
         int          re;
         ra = 16'($urandom);
         rb = 16'($urandom);
         rm = 2'($urandom % 4);
         re = 1 + int'($urandom % 70);
         run_frame(ra, rb, rm, re, ($urandom % 4) != 0, ($urandom % 5) == 0);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule